// File: doc/BRIEF.md
# Page-Relative Branch Resolution Unit

This unit works out the next program counter for the branch instructions of a small 8-bit microcontroller core. The core's decoder hands it, in a single `start` cycle, the branch kind, the address of the branch opcode, the second instruction byte, the three address or bit-select bits that sit in the opcode, and a snapshot of the status it may test. That status is the accumulator, carry, two user flags, the host interface's input-full and output-full flags, and the memory-bank select bit. It also receives the current value of the working register named by the decrement-and-jump form. Instruction fetch, opcode decoding and the register file stay outside.

Conditional forms change only the low byte of the program counter, so their targets stay inside one 256-byte page. That page is the page of the byte that follows the two-byte instruction. The long jump builds a full 12-bit address from the bank bit, three opcode bits and the second byte. The indirect jump reads a byte of program memory addressed by the accumulator, using a request and valid handshake, and then replaces the low byte with it. A one-cycle `done` pulse marks the cycle in which `pc_next`, `taken` and any register write-back are valid.

Top module: `pg_branch_unit`

## Requirements
- R1: After reset, `done`, `taken`, `reg_wr` and `mem_req` are 0, and `pc_next` is 0.
- R2: For any form other than the indirect jump, `start` in an idle cycle gives a single-cycle `done` in the next cycle. A taken conditional form gives `pc_next` = {upper 4 bits of (`pc_in`+2), `imm`}.
- R3: A conditional form that is not taken gives `pc_next` = (`pc_in`+2) mod 4096 and `taken` = 0.
- R4: The flag forms are selected by `kind`. Code 4 branches on carry=1 and code 5 on carry=0. Code 6 branches on user flag 0=1 and code 7 on user flag 1=1. Code 8 branches on host input-full=0 and code 9 on host output-full=1.
- R5: The bit-test form (`kind`=3) branches when `acc[sel]` is 1.
- R6: The decrement form (`kind`=2) sets `reg_out` = (`reg_in`-1) mod 256 and pulses `reg_wr` together with `done`. It branches only when that result is not zero. No other form pulses `reg_wr`.
- R7: The long jump (`kind`=0) always branches, with `pc_next` = {`bank_sel`, `sel`, `imm`}.
- R8: The indirect jump (`kind`=1) raises `mem_req` in the next cycle with `mem_addr` = `acc`. It holds both until `mem_valid` is seen. In the following cycle it pulses `done` with `taken`=1 and `pc_next` = {upper 4 bits of (`pc_in`+1), `mem_data`}, and it drops `mem_req`.
- R9: Page selection follows the advanced address. `pc_in`=0x0FE takes its target from page 0x1, and `pc_in`=0xFFE wraps to page 0x0.
- R10: `start` has no effect while an indirect fetch is pending. No `done` is produced for it, and the request and its address are kept.
- R11: Kind codes 10 to 15 complete like a conditional form that is never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to resolve a branch |
| kind | input | 4 | Branch kind code |
| pc_in | input | 12 | Address of the branch opcode |
| imm | input | 8 | Second instruction byte |
| sel | input | 3 | Opcode address bits / accumulator bit index |
| acc | input | 8 | Accumulator |
| carry | input | 1 | Carry flag |
| uflag0 | input | 1 | User flag 0 |
| uflag1 | input | 1 | User flag 1 |
| host_in_full | input | 1 | Host input buffer full |
| host_out_full | input | 1 | Host output buffer full |
| bank_sel | input | 1 | Memory-bank select bit |
| reg_in | input | 8 | Current value of the selected working register |
| mem_data | input | 8 | Program-memory byte returned for the indirect jump |
| mem_valid | input | 1 | `mem_data` is valid |
| mem_req | output | 1 | Program-memory read request |
| mem_addr | output | 8 | Program-memory read address (low byte) |
| done | output | 1 | Result valid this cycle |
| taken | output | 1 | Branch was taken |
| pc_next | output | 12 | Next program counter |
| reg_wr | output | 1 | Write-back strobe for the decremented register |
| reg_out | output | 8 | Decremented register value |

## Verification
The hardest situation to reach from the ports is a new `start` that arrives while an indirect fetch is still outstanding. The rest of the unit finishes in one cycle, so the only open window is the one the bench creates by holding `mem_valid` low for several cycles after an indirect request. The bench drives a long-jump `start` into that window and checks two things: no `done` appears, and the pending address survives. The page-crossing and 4096 wrap cases are reached by placing the opcode in the last two bytes of a page and in the last two bytes of the address space.

// File: rtl/pbu_pkg.sv
package pbu_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;
  localparam int KIND_W = 4;
  localparam int PC_W   = 1 + SEL_W + BYTE_W;
  localparam int PAGE_W = PC_W - BYTE_W;

  typedef enum logic [KIND_W-1:0] {
    BR_LONG      = 4'd0,
    BR_TABLE     = 4'd1,
    BR_DECNZ     = 4'd2,
    BR_BIT       = 4'd3,
    BR_CY        = 4'd4,
    BR_NCY       = 4'd5,
    BR_UF0       = 4'd6,
    BR_UF1       = 4'd7,
    BR_IN_EMPTY  = 4'd8,
    BR_OUT_FULL  = 4'd9
  } br_kind_e;

  typedef struct packed {
    logic cy;
    logic uf0;
    logic uf1;
    logic in_full;
    logic out_full;
  } br_status_t;

  // Program counter advance with wrap at the top of the address space.
  function automatic logic [PC_W-1:0] pc_advance(input logic [PC_W-1:0] pc,
                                                 input int unsigned step);
    return pc + PC_W'(step);
  endfunction

  // Low byte replaced, page kept.
  function automatic logic [PC_W-1:0] in_page(input logic [PC_W-1:0] base,
                                              input logic [BYTE_W-1:0] lo);
    return {base[PC_W-1:BYTE_W], lo};
  endfunction
endpackage

// File: rtl/pbu_cond.sv
module pbu_cond
  import pbu_pkg::*;
(
  input  br_kind_e           kind,
  input  logic [SEL_W-1:0]   sel,
  input  logic [BYTE_W-1:0]  acc,
  input  br_status_t         st,
  input  logic [BYTE_W-1:0]  dec_val,
  output logic               take
);
  always_comb begin
    case (kind)
      BR_LONG, BR_TABLE: take = 1'b1;
      BR_DECNZ:          take = (dec_val != '0);
      BR_BIT:            take = acc[sel];
      BR_CY:             take = st.cy;
      BR_NCY:            take = ~st.cy;
      BR_UF0:            take = st.uf0;
      BR_UF1:            take = st.uf1;
      BR_IN_EMPTY:       take = ~st.in_full;
      BR_OUT_FULL:       take = st.out_full;
      default:           take = 1'b0;
    endcase
  end
endmodule

// File: rtl/pbu_target.sv
module pbu_target
  import pbu_pkg::*;
(
  input  br_kind_e           kind,
  input  logic [PC_W-1:0]    pc,
  input  logic [BYTE_W-1:0]  imm,
  input  logic [SEL_W-1:0]   sel,
  input  logic               bank,
  input  logic               take,
  output logic [PC_W-1:0]    target
);
  logic [PC_W-1:0] fall;
  assign fall = pc_advance(pc, 2);

  always_comb begin
    if (kind == BR_LONG)
      target = {bank, sel, imm};
    else if (take)
      target = in_page(fall, imm);
    else
      target = fall;
  end
endmodule

// File: rtl/pg_branch_unit.sv
module pg_branch_unit
  import pbu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [KIND_W-1:0] kind,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [BYTE_W-1:0] imm,
  input  logic [SEL_W-1:0]  sel,
  input  logic [BYTE_W-1:0] acc,
  input  logic              carry,
  input  logic              uflag0,
  input  logic              uflag1,
  input  logic              host_in_full,
  input  logic              host_out_full,
  input  logic              bank_sel,
  input  logic [BYTE_W-1:0] reg_in,
  input  logic [BYTE_W-1:0] mem_data,
  input  logic              mem_valid,
  output logic              mem_req,
  output logic [BYTE_W-1:0] mem_addr,
  output logic              done,
  output logic              taken,
  output logic [PC_W-1:0]   pc_next,
  output logic              reg_wr,
  output logic [BYTE_W-1:0] reg_out
);
  br_kind_e          k;
  br_status_t        st;
  logic [BYTE_W-1:0] dec_val;
  logic              take;
  logic [PC_W-1:0]   tgt;
  logic [PC_W-1:0]   after_op;
  logic              busy_q;
  logic [PAGE_W-1:0] page_q;
  logic [BYTE_W-1:0] addr_q;
  logic              done_q, taken_q, wr_q;
  logic [PC_W-1:0]   pc_q;
  logic [BYTE_W-1:0] rout_q;

  // Named events for the checks below.
  logic accept_fast, accept_fetch, fetch_end;

  assign k        = br_kind_e'(kind);
  assign st       = '{cy: carry, uf0: uflag0, uf1: uflag1,
                      in_full: host_in_full, out_full: host_out_full};
  assign dec_val  = reg_in - BYTE_W'(1);
  assign after_op = pc_advance(pc_in, 1);

  assign accept_fetch = start && !busy_q && (k == BR_TABLE);
  assign accept_fast  = start && !busy_q && (k != BR_TABLE);
  assign fetch_end    = busy_q && mem_valid;

  pbu_cond u_cond (
    .kind(k), .sel(sel), .acc(acc), .st(st), .dec_val(dec_val), .take(take)
  );

  pbu_target u_target (
    .kind(k), .pc(pc_in), .imm(imm), .sel(sel), .bank(bank_sel),
    .take(take), .target(tgt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      page_q  <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      taken_q <= 1'b0;
      wr_q    <= 1'b0;
      pc_q    <= '0;
      rout_q  <= '0;
    end else begin
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      if (accept_fetch) begin
        busy_q <= 1'b1;
        addr_q <= acc;
        page_q <= after_op[PC_W-1:BYTE_W];
      end else if (accept_fast) begin
        done_q  <= 1'b1;
        taken_q <= take;
        pc_q    <= tgt;
        if (k == BR_DECNZ) begin
          wr_q   <= 1'b1;
          rout_q <= dec_val;
        end
      end else if (fetch_end) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        taken_q <= 1'b1;
        pc_q    <= {page_q, mem_data};
      end
    end
  end

  assign mem_req  = busy_q;
  assign mem_addr = addr_q;
  assign done     = done_q;
  assign taken    = taken_q;
  assign pc_next  = pc_q;
  assign reg_wr   = wr_q;
  assign reg_out  = rout_q;

  p_fixed_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_fast |=> (done && !mem_req));

  p_fetch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  p_fetch_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid) |=> (done && taken && !mem_req));

  p_wr_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> done);

  p_quiet_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> !done);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);
endmodule

// File: tb/tb_pg_branch_unit.sv
module tb_pg_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  kind = '0;
  logic [11:0] pc_in = '0;
  logic [7:0]  imm = '0;
  logic [2:0]  sel = '0;
  logic [7:0]  acc = '0;
  logic        carry = 0, uflag0 = 0, uflag1 = 0;
  logic        host_in_full = 0, host_out_full = 0, bank_sel = 0;
  logic [7:0]  reg_in = '0;
  logic [7:0]  mem_data = '0;
  logic        mem_valid = 1'b0;
  logic        mem_req, done, taken, reg_wr;
  logic [7:0]  mem_addr, reg_out;
  logic [11:0] pc_next;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pg_branch_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .pc_in(pc_in),
    .imm(imm), .sel(sel), .acc(acc), .carry(carry), .uflag0(uflag0),
    .uflag1(uflag1), .host_in_full(host_in_full), .host_out_full(host_out_full),
    .bank_sel(bank_sel), .reg_in(reg_in), .mem_data(mem_data),
    .mem_valid(mem_valid), .mem_req(mem_req), .mem_addr(mem_addr),
    .done(done), .taken(taken), .pc_next(pc_next), .reg_wr(reg_wr),
    .reg_out(reg_out)
  );

  // flags = {carry, uflag0, uflag1, host_in_full, host_out_full, bank_sel}
  typedef struct packed {
    logic [3:0]  kind;
    logic [11:0] pc;
    logic [7:0]  imm;
    logic [2:0]  sel;
    logic [7:0]  acc;
    logic [5:0]  fl;
    logic [7:0]  rg;
    logic [11:0] epc;
    logic        et;
    logic [7:0]  ereg;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{4'd4, 12'h123, 8'h45, 3'd0, 8'h00, 6'b100000, 8'h00, 12'h145, 1'b1, 8'h00},
    '{4'd4, 12'h123, 8'h45, 3'd0, 8'h00, 6'b000000, 8'h00, 12'h125, 1'b0, 8'h00},
    '{4'd5, 12'h200, 8'h10, 3'd0, 8'h00, 6'b000000, 8'h00, 12'h210, 1'b1, 8'h00},
    '{4'd5, 12'h200, 8'h10, 3'd0, 8'h00, 6'b100000, 8'h00, 12'h202, 1'b0, 8'h00},
    '{4'd6, 12'h300, 8'hAA, 3'd0, 8'h00, 6'b010000, 8'h00, 12'h3AA, 1'b1, 8'h00},
    '{4'd7, 12'h300, 8'hAA, 3'd0, 8'h00, 6'b010000, 8'h00, 12'h302, 1'b0, 8'h00},
    '{4'd7, 12'h0FE, 8'h33, 3'd0, 8'h00, 6'b001000, 8'h00, 12'h133, 1'b1, 8'h00},
    '{4'd8, 12'h400, 8'h01, 3'd0, 8'h00, 6'b000000, 8'h00, 12'h401, 1'b1, 8'h00},
    '{4'd8, 12'h400, 8'h01, 3'd0, 8'h00, 6'b000100, 8'h00, 12'h402, 1'b0, 8'h00},
    '{4'd9, 12'h500, 8'hF0, 3'd0, 8'h00, 6'b000010, 8'h00, 12'h5F0, 1'b1, 8'h00},
    '{4'd9, 12'h500, 8'hF0, 3'd0, 8'h00, 6'b000000, 8'h00, 12'h502, 1'b0, 8'h00},
    '{4'd3, 12'h600, 8'h77, 3'd5, 8'h20, 6'b000000, 8'h00, 12'h677, 1'b1, 8'h00},
    '{4'd3, 12'h600, 8'h77, 3'd5, 8'hDF, 6'b000000, 8'h00, 12'h602, 1'b0, 8'h00},
    '{4'd3, 12'hFFE, 8'h99, 3'd0, 8'h01, 6'b000000, 8'h00, 12'h099, 1'b1, 8'h00},
    '{4'd2, 12'h700, 8'h20, 3'd0, 8'h00, 6'b000000, 8'h05, 12'h720, 1'b1, 8'h04},
    '{4'd2, 12'h700, 8'h20, 3'd0, 8'h00, 6'b000000, 8'h01, 12'h702, 1'b0, 8'h00},
    '{4'd2, 12'h700, 8'h20, 3'd0, 8'h00, 6'b000000, 8'h00, 12'h720, 1'b1, 8'hFF},
    '{4'd0, 12'h100, 8'h5A, 3'd3, 8'h00, 6'b000001, 8'h00, 12'hB5A, 1'b1, 8'h00},
    '{4'd0, 12'h100, 8'h00, 3'd7, 8'h00, 6'b111110, 8'h00, 12'h700, 1'b1, 8'h00},
    '{4'd12, 12'h0FF, 8'h44, 3'd0, 8'h00, 6'b111111, 8'h00, 12'h101, 1'b0, 8'h00}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] k);
    case (k)
      4'd0: return "R7";
      4'd2: return "R6";
      4'd3: return "R5";
      4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: return "R4";
      default: return "R11";
    endcase
  endfunction

  // Drive a request at a falling edge; results are sampled at the next falling edge.
  task automatic issue(input vec_t v);
    @(negedge clk);
    kind = v.kind; pc_in = v.pc; imm = v.imm; sel = v.sel; acc = v.acc;
    {carry, uflag0, uflag1, host_in_full, host_out_full, bank_sel} = v.fl;
    reg_in = v.rg;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 0 && taken == 0 && reg_wr == 0 && mem_req == 0, "R1",
          {done, taken, reg_wr, mem_req}, 0);
    check(pc_next == 0, "R1", pc_next, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i]);
      check(done == 1'b1, "R2", done, 1);
      check(taken == VECS[i].et, req_of(VECS[i].kind), taken, VECS[i].et);
      check(pc_next == VECS[i].epc, VECS[i].et ? "R2" : "R3", pc_next, VECS[i].epc);
      check(reg_wr == (VECS[i].kind == 4'd2), "R6", reg_wr, VECS[i].kind == 4'd2);
      if (VECS[i].kind == 4'd2)
        check(reg_out == VECS[i].ereg, "R6", reg_out, VECS[i].ereg);
      @(negedge clk);
      check(done == 1'b0, "R2", done, 0);
    end

    // R9: page after the instruction, both across a page and across the top
    issue('{4'd4, 12'h0FE, 8'h10, 3'd0, 8'h00, 6'b100000, 8'h00, 12'h000, 1'b0, 8'h00});
    check(pc_next == 12'h110, "R9", pc_next, 12'h110);
    issue('{4'd5, 12'hFFE, 8'h10, 3'd0, 8'h00, 6'b100000, 8'h00, 12'h000, 1'b0, 8'h00});
    check(pc_next == 12'h000, "R9", pc_next, 12'h000);

    // R8: indirect fetch with a delayed valid; R10: start ignored meanwhile
    issue('{4'd1, 12'h2FF, 8'h00, 3'd0, 8'h3C, 6'b000000, 8'h00, 12'h000, 1'b0, 8'h00});
    check(mem_req == 1'b1 && done == 1'b0, "R8", {mem_req, done}, 2'b10);
    check(mem_addr == 8'h3C, "R8", mem_addr, 8'h3C);
    issue('{4'd0, 12'h100, 8'h5A, 3'd3, 8'h00, 6'b000001, 8'h00, 12'h000, 1'b0, 8'h00});
    check(done == 1'b0, "R10", done, 0);
    check(mem_req == 1'b1 && mem_addr == 8'h3C, "R10", mem_addr, 8'h3C);
    @(negedge clk);
    check(mem_req == 1'b1 && done == 1'b0, "R8", {mem_req, done}, 2'b10);
    mem_data = 8'h81; mem_valid = 1'b1;
    @(negedge clk);
    mem_valid = 1'b0;
    check(done == 1'b1 && taken == 1'b1 && mem_req == 1'b0, "R8",
          {done, taken, mem_req}, 3'b110);
    check(pc_next == 12'h381, "R8", pc_next, 12'h381);
    check(reg_wr == 1'b0, "R6", reg_wr, 0);
    @(negedge clk);
    check(done == 1'b0, "R8", done, 0);

    // R1: reset in the middle of a pending fetch
    issue('{4'd1, 12'h010, 8'h00, 3'd0, 8'h55, 6'b000000, 8'h00, 12'h000, 1'b0, 8'h00});
    rst_n = 1'b0;
    #1;
    check(mem_req == 1'b0 && done == 1'b0 && pc_next == 0, "R1",
          {mem_req, done, pc_next}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule